// File: doc/BRIEF.md
# Cascadable Down-Counting Timer Pair

Two 16-bit down-counters share one clock domain and a free-running prescaler. Each counter has a reload value and a one-byte mode. The mode selects the tick source and holds an initialize flag and a run flag. The lower counter ticks on the undivided clock, on one cycle in eight, or on one cycle in thirty-two. The upper counter can use the same sources. It can also be chained to the lower counter's underflow, so the pair behaves as a single 32-bit down-counter.

When a counter passes zero it reloads itself and raises a single-cycle interrupt pulse. Software writes both mode bytes as one 16-bit word and both reload values as one 32-bit word. It reads the count through a snapshot register that captures both halves on the same edge. With a reload value of all ones, the bitwise complement of the snapshot is the number of ticks since the counters were started.

Top module: `casc_timer_pair`

## Requirements
- R1: After reset both counters, both reload values, both mode bytes, the prescaler and the snapshot are zero, and both interrupt outputs are low.
- R2: A write on `mode_wr` stores byte [7:0] as the lower mode and byte [15:8] as the upper mode. A write on `base_wr` stores [15:0] as the lower reload value and [31:16] as the upper one. Within a mode byte, bits 1:0 are the source (00 every cycle, 01 divide by 8, 10 divide by 32, 11 chained), bit 6 is initialize and bit 7 is run.
- R3: While a counter's initialize bit is set, the counter is loaded from its stored reload value on every cycle and does not count, even when run is also set.
- R4: A counter decrements by one on each edge where run is set, initialize is clear and its source ticks. Writing a mode byte of zero stops the counter and it holds its value.
- R5: The prescaler is a 5-bit counter that starts at 0 after reset and steps every cycle. Source 01 ticks on edges where its low three bits are all ones, and source 10 ticks where all five bits are ones. On the lower counter, source 11 never ticks.
- R6: A counter that is at zero when it ticks reloads from its reload value, so its period is the reload value plus one ticks.
- R7: With the upper source set to 11, the upper counter ticks exactly on the edges where the lower counter underflows.
- R8: `irq_lo` is high for one cycle after each edge on which the lower counter underflows, and `irq_hi` is high for one cycle after each edge on which the upper counter underflows.
- R9: On each edge with `snap_req` high, `count_o` takes {upper, lower} as both counters stood before that edge.
- R10: With both reload values all ones, the pair chained and the lower source set to 00, the complement of the snapshot equals the number of ticks since counting began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state and the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for both mode bytes |
| mode_wdata | input | 16 | Upper mode in [15:8], lower mode in [7:0] |
| base_wr | input | 1 | Write strobe for both reload values |
| base_wdata | input | 32 | Upper reload in [31:16], lower reload in [15:0] |
| snap_req | input | 1 | Capture both counters into `count_o` |
| count_o | output | 32 | Snapshot of {upper, lower} |
| irq_lo | output | 1 | Lower underflow pulse |
| irq_hi | output | 1 | Upper underflow pulse |

## Verification
The critical coincidence is a lower underflow and an upper reload on the same edge in chained mode. If the design handles it wrongly, the snapshot captures one half before the carry and the other half after it, or `irq_hi` fires without `irq_lo`. The bench uses small reload values (4 and 2), so both halves wrap together every fifteen ticks. It captures a snapshot on every edge and compares each one against the pair computed arithmetically from the tick count. It also checks `irq_lo` and `irq_hi` against underflow times predicted from the same count.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
    typedef enum logic [1:0] {
        SRC_DIV1  = 2'b00,
        SRC_DIV8  = 2'b01,
        SRC_DIV32 = 2'b10,
        SRC_CHAIN = 2'b11
    } src_e;

    typedef struct packed {
        logic       run;
        logic       init;
        logic [3:0] spare;
        src_e       src;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
    localparam int PRE_W  = 5;
endpackage

// File: rtl/ctp_prescaler.sv
module ctp_prescaler
    import ctp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic stb8_o,
    output logic stb32_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + 1'b1;
        stb8_o   = &st_q.pre[2:0];
        stb32_o  = &st_q.pre;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_STROBE_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        stb32_o |-> stb8_o); // R5
    AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        stb8_o |=> !stb8_o); // R5
endmodule

// File: rtl/ctp_timer_unit.sv
module ctp_timer_unit
    import ctp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_wr_i,
    input  mode_t        mode_wdata_i,
    input  logic         base_wr_i,
    input  logic [W-1:0] base_wdata_i,
    input  logic         stb8_i,
    input  logic         stb32_i,
    input  logic         chain_i,
    output logic [W-1:0] cnt_o,
    output logic         uf_o,
    output logic         irq_o
);
    typedef struct packed {
        mode_t        mode;
        logic [W-1:0] base;
        logic [W-1:0] cnt;
        logic         irq;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic     tick;
    logic     step;

    always_comb begin
        unique case (st_q.mode.src)
            SRC_DIV1:  tick = 1'b1;
            SRC_DIV8:  tick = stb8_i;
            SRC_DIV32: tick = stb32_i;
            default:   tick = chain_i;
        endcase
        step = st_q.mode.run & ~st_q.mode.init & tick;
        uf_o = step & (st_q.cnt == '0);

        st_d = st_q;
        if (mode_wr_i) st_d.mode = mode_wdata_i;
        if (base_wr_i) st_d.base = base_wdata_i;
        if (st_q.mode.init)  st_d.cnt = st_q.base;
        else if (uf_o)       st_d.cnt = st_q.base;
        else if (step)       st_d.cnt = st_q.cnt - 1'b1;
        st_d.irq = uf_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign irq_o = st_q.irq;

    AST_INIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode.init |=> st_q.cnt == $past(st_q.base)); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.mode.run && !st_q.mode.init) |=> $stable(st_q.cnt)); // R4
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - 1'b1); // R4
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        uf_o |=> st_q.cnt == $past(st_q.base)); // R6
endmodule

// File: rtl/casc_timer_pair.sv
module casc_timer_pair
    import ctp_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_wr,
    input  logic [2*MODE_W-1:0] mode_wdata,
    input  logic                base_wr,
    input  logic [2*HALF_W-1:0] base_wdata,
    input  logic                snap_req,
    output logic [2*HALF_W-1:0] count_o,
    output logic                irq_lo,
    output logic                irq_hi
);
    localparam int NUM_UNITS = 2;
    localparam int FULL_W    = NUM_UNITS * HALF_W;

    logic                              stb8, stb32;
    logic [NUM_UNITS-1:0]              uf_w;
    logic [NUM_UNITS-1:0]              irq_w;
    logic [NUM_UNITS-1:0][HALF_W-1:0]  cnt_w;

    ctp_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb8_o  (stb8),
        .stb32_o (stb32)
    );

    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
        logic chain_in;
        if (i == 0) begin : g_first
            assign chain_in = 1'b0;
        end else begin : g_chained
            assign chain_in = uf_w[i-1];
        end

        ctp_timer_unit #(.W(HALF_W)) u_unit (
            .clk          (clk),
            .rst_n        (rst_n),
            .mode_wr_i    (mode_wr),
            .mode_wdata_i (mode_t'(mode_wdata[MODE_W*i +: MODE_W])),
            .base_wr_i    (base_wr),
            .base_wdata_i (base_wdata[HALF_W*i +: HALF_W]),
            .stb8_i       (stb8),
            .stb32_i      (stb32),
            .chain_i      (chain_in),
            .cnt_o        (cnt_w[i]),
            .uf_o         (uf_w[i]),
            .irq_o        (irq_w[i])
        );
    end

    typedef struct packed {
        logic [FULL_W-1:0] snap;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (snap_req) st_d.snap = cnt_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.snap;
    assign irq_lo  = irq_w[0];
    assign irq_hi  = irq_w[1];

    AST_SNAP_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> count_o == {$past(cnt_w[1]), $past(cnt_w[0])}); // R9
    AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(count_o)); // R9
endmodule

// File: tb/casc_timer_pair_bench.sv
module casc_timer_pair_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [15:0] mode_wdata = '0;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        snap_req = 1'b0;
    logic [31:0] count_o;
    logic        irq_lo, irq_hi;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [4:0] pm;

    always #5 clk = ~clk;

    casc_timer_pair u_casc_timer_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .base_wr    (base_wr),
        .base_wdata (base_wdata),
        .snap_req   (snap_req),
        .count_o    (count_o),
        .irq_lo     (irq_lo),
        .irq_hi     (irq_hi)
    );

    // arithmetic phase of the divide taps, counted from reset release
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) pm <= '0;
        else        pm <= pm + 5'd1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // program reload values, then an initialize word, then a run word
    task automatic setup(input logic [31:0] base, input logic [15:0] m_init, input logic [15:0] m_run);
        @(negedge clk);
        base_wr = 1'b1; base_wdata = base;
        @(negedge clk);
        base_wr = 1'b0; mode_wr = 1'b1; mode_wdata = m_init;
        @(negedge clk);
        mode_wdata = m_run;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic run_seq(input int n, input int src_lo, input bit chained,
                           input int bl, input int bh, input bit comp_chk);
        int k = 0;
        for (int j = 0; j < n; j++) begin
            bit tk;
            int lo, hi, u;
            bit uf_lo, uf_hi;
            case (src_lo)
                0: tk = 1'b1;
                1: tk = (pm[2:0] == 3'b111);
                default: tk = (pm == 5'b11111);
            endcase
            lo = bl - (k % (bl + 1));
            u  = k / (bl + 1);
            hi = chained ? bh - (u % (bh + 1)) : bh;
            uf_lo = tk && (lo == 0);
            uf_hi = chained && uf_lo && (hi == 0);
            @(negedge clk);
            check(count_o == {hi[15:0], lo[15:0]}, "R9/R4/R6/R7 count", count_o, {hi[15:0], lo[15:0]});
            check(irq_lo == uf_lo, "R8 irq_lo", {31'd0, irq_lo}, {31'd0, uf_lo});
            if (chained)
                check(irq_hi == uf_hi, "R8/R7 irq_hi", {31'd0, irq_hi}, {31'd0, uf_hi});
            if (comp_chk)
                check(~count_o == k, "R10 up-count", ~count_o, k);
            k += int'(tk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(count_o == 32'd0, "R1 count", count_o, 32'd0);
        check(irq_lo == 1'b0 && irq_hi == 1'b0, "R1 irq", {30'd0, irq_hi, irq_lo}, 32'd0);
        rst_n = 1'b1;
        snap_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(count_o == 32'd0, "R1 count after release", count_o, 32'd0);

        // R7 R8 R9: chained /1, both halves wrap together every 15 ticks
        setup(32'h0002_0004, 16'h4340, 16'h8380);
        run_seq(50, 0, 1'b1, 4, 2, 1'b0);

        // R5: lower /8, upper loaded and idle (R2 byte placement)
        setup(32'h0007_0003, 16'h4041, 16'h0081);
        run_seq(80, 1, 1'b0, 3, 7, 1'b0);

        // R5: lower /32
        setup(32'h0009_0001, 16'h4042, 16'h0082);
        run_seq(140, 2, 1'b0, 1, 9, 1'b0);

        // R3: initialize wins over run
        setup(32'h1234_5678, 16'hC0C0, 16'hC0C0);
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            check(count_o == 32'h1234_5678, "R3 init holds", count_o, 32'h1234_5678);
        end

        // R4: mode zero stops both counters
        setup(32'h0003_0005, 16'h4340, 16'h8380);
        repeat (7) @(negedge clk);
        mode_wr = 1'b1; mode_wdata = 16'h0000;
        @(negedge clk);
        mode_wr = 1'b0;
        repeat (2) @(negedge clk);
        held = count_o;
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            check(count_o == held, "R4 stopped", count_o, held);
            check(irq_lo == 1'b0, "R4 no irq when stopped", {31'd0, irq_lo}, 32'd0);
        end

        // R5: lower source 11 never ticks
        setup(32'h0000_0006, 16'h0043, 16'h0083);
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            check(count_o[15:0] == 16'h0006, "R5 lower chained source idle", count_o, 32'h6);
        end

        // R10: all-ones reload, complement is elapsed ticks
        setup(32'hFFFF_FFFF, 16'h4340, 16'h8380);
        run_seq(12, 0, 1'b1, 65535, 65535, 1'b1);

        finish_run();
    end
endmodule